// File: doc/BRIEF.md
# DMA Controller Register Programming Port

This block is the processor-facing slave port of a four-channel DMA controller. A host reaches it through a 4-bit register offset, an active-low select and single-cycle read and write strobes. Accesses are honoured only while the bus grant from the host is low, so the controller can be programmed while idle and while it is still waiting for the grant. Each channel has a 16-bit address register and a 16-bit count register. The 8-bit data path reaches them one byte at a time through a shared byte pointer, low byte first.

The port also holds the controller-wide command byte, one 6-bit mode field per channel, the per-channel mask and software-request bits, a status byte and an 8-bit temporary byte. Some offsets do not take data. A strobe at those offsets acts as a command: it moves the byte pointer, clears the whole port, clears the mode readback counter or unmasks all channels. The sequencer and counting logic read the stored values on plain output buses. The sequencer reports terminal counts and loads the temporary byte through two inputs of its own.

Read data is registered. It appears on `rdata` with `rvalid` high in the cycle after an accepted read strobe and holds until the next accepted read. There is no back-pressure, because every accepted access completes in one cycle. These are control pins, not a stream.

Top module: `dmac_cfg_port`

## Requirements
- R1: An access is accepted only when `cs_n` is 0, `hold_ack` is 0 and exactly one of `rd_stb`/`wr_stb` is 1. Any other combination changes no register and gives no `rvalid`.
- R2: A single byte pointer, cleared by reset, selects the low byte (0) or the high byte (1) of the 16-bit channel registers. Every accepted read or write at offsets 0–7 uses the current pointer and then inverts it.
- R3: At offsets 0–7, bits [2:1] of the offset give the channel and bit 0 picks the address register (0) or the count register (1). A write updates only the addressed byte of that register.
- R4: A write at offset 8 stores the command byte. A read at offset 8 returns `{req_lines, tc_flags}` and then clears the terminal-count flags, except that a flag set by `tc_set` in the same cycle stays set.
- R5: A write at offset 9 sets the request bit of channel `wdata[1:0]` to `wdata[2]`. A read at offset 9 returns `{4'b0, request bits}`.
- R6: A write at offset 10 sets the mask bit of channel `wdata[1:0]` to `wdata[2]`. A write at offset 15 loads all mask bits from `wdata[3:0]`. Reads at offset 10 or 15 return `{4'b0, mask}`.
- R7: A write at offset 11 stores `wdata[7:2]` as the mode of channel `wdata[1:0]`. A read at offset 11 returns `{mode[ptr], ptr}` and then advances the 2-bit readback counter `ptr`, wrapping after 3. A read at offset 14 clears `ptr` and returns 0.
- R8: A write at offset 12 clears the byte pointer. A read at offset 12 sets it and returns 0.
- R9: A write at offset 13 is a master clear. It zeroes the command byte, the request bits, the terminal-count flags, the temporary byte, the byte pointer and the mode counter, and it sets every mask bit. Channel registers and modes keep their values. A read at offset 13 returns the temporary byte.
- R10: A write at offset 14 clears all mask bits.
- R11: While `rst` is high, every mask bit is set. The command byte, request bits, flags, temporary byte, modes, channel registers, byte pointer, mode counter and `rvalid` are all 0.
- R12: `rvalid` is high exactly in the cycle after an accepted read, and `rdata` keeps its value otherwise. A pulse on `tc_set[n]` sets flag n. `tmp_load` loads `tmp_data` into the temporary byte, and a master clear in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Port select, active low |
| hold_ack | input | 1 | Bus grant from host; programming is blocked while high |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| rvalid | output | 1 | Read data valid |
| req_lines | input | 4 | Live channel request lines, shown in status |
| tc_set | input | 4 | Per-channel terminal-count pulses from the sequencer |
| tmp_load | input | 1 | Load enable for the temporary byte |
| tmp_data | input | 8 | Byte for the temporary register |
| cmd_o | output | 8 | Command byte |
| mode_o | output | 24 | Channel modes, 6 bits per channel, channel 0 lowest |
| mask_o | output | 4 | Channel mask bits |
| swreq_o | output | 4 | Software request bits |
| chaddr_o | output | 64 | Channel address registers, 16 bits each, channel 0 lowest |
| chcnt_o | output | 64 | Channel count registers, 16 bits each, channel 0 lowest |

## Verification
The bench targets the byte pointer across mixed operations:
- a read between the two halves of a write pair;
- explicit pointer set and clear;
- a master clear with the pointer left at high.

A pointer that failed to advance on reads, or that survived the clear, would splice bytes into the wrong halves. The bench also fires a terminal-count pulse in the same cycle as a status read. A design that let the clear win would silently lose that event.

The mode readback counter is walked past its wrap point and then cleared mid-walk. Gated, overlapped and double-strobe accesses are also driven; a decoder that looked at the select alone would corrupt the command byte.

// File: rtl/dmac_cfg_pkg.sv
package dmac_cfg_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int REG_W  = 16;
  localparam int MODE_W = 6;

  localparam logic [3:0] OFS_CMD   = 4'd8;
  localparam logic [3:0] OFS_REQ   = 4'd9;
  localparam logic [3:0] OFS_SMASK = 4'd10;
  localparam logic [3:0] OFS_MODE  = 4'd11;
  localparam logic [3:0] OFS_PTR   = 4'd12;
  localparam logic [3:0] OFS_MCLR  = 4'd13;
  localparam logic [3:0] OFS_UNMSK = 4'd14;
  localparam logic [3:0] OFS_AMASK = 4'd15;

  typedef struct packed {
    logic ch_wr;
    logic ch_rd;
    logic cmd_wr;
    logic stat_rd;
    logic req_wr;
    logic req_rd;
    logic smask_wr;
    logic smask_rd;
    logic mode_wr;
    logic mode_rd;
    logic ptrclr_wr;
    logic ptrset_rd;
    logic mclr_wr;
    logic tmp_rd;
    logic unmask_wr;
    logic mctrclr_rd;
    logic amask_wr;
    logic amask_rd;
  } dec_t;
endpackage

// File: rtl/dmac_cfg_decode.sv
module dmac_cfg_decode
  import dmac_cfg_pkg::*;
(
  input  logic       cs_n,
  input  logic       hold_ack,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic [3:0] addr,
  output dec_t       dec,
  output logic       acc_rd
);
  logic take, wr, rd;

  always_comb begin
    take   = !cs_n && !hold_ack && (rd_stb != wr_stb);
    wr     = take && wr_stb;
    rd     = take && rd_stb;
    acc_rd = rd;
    dec    = '0;
    dec.ch_wr = wr && !addr[3];
    dec.ch_rd = rd && !addr[3];
    case (addr)
      OFS_CMD:   begin dec.cmd_wr    = wr; dec.stat_rd    = rd; end
      OFS_REQ:   begin dec.req_wr    = wr; dec.req_rd     = rd; end
      OFS_SMASK: begin dec.smask_wr  = wr; dec.smask_rd   = rd; end
      OFS_MODE:  begin dec.mode_wr   = wr; dec.mode_rd    = rd; end
      OFS_PTR:   begin dec.ptrclr_wr = wr; dec.ptrset_rd  = rd; end
      OFS_MCLR:  begin dec.mclr_wr   = wr; dec.tmp_rd     = rd; end
      OFS_UNMSK: begin dec.unmask_wr = wr; dec.mctrclr_rd = rd; end
      OFS_AMASK: begin dec.amask_wr  = wr; dec.amask_rd   = rd; end
      default: ;
    endcase
  end
endmodule

// File: rtl/dmac_cfg_chregs.sv
module dmac_cfg_chregs
  import dmac_cfg_pkg::*;
#(
  parameter int N_CH = NCH,
  parameter int RW   = REG_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [$clog2(N_CH)-1:0] ch_sel,
  input  logic                    is_cnt,
  input  logic                    byte_hi,
  input  logic [7:0]              wdata,
  output logic [N_CH*RW-1:0]      addr_flat,
  output logic [N_CH*RW-1:0]      cnt_flat
);
  localparam int SW = $clog2(N_CH);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [RW-1:0] adr_q, cnt_q;
    logic          hit;
    assign hit = wr_en && (ch_sel == SW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        adr_q <= '0;
        cnt_q <= '0;
      end else if (hit) begin
        if (is_cnt) begin
          if (byte_hi) cnt_q[RW-1 -: 8] <= wdata;
          else         cnt_q[7:0]       <= wdata;
        end else begin
          if (byte_hi) adr_q[RW-1 -: 8] <= wdata;
          else         adr_q[7:0]       <= wdata;
        end
      end
    end

    assign addr_flat[g*RW +: RW] = adr_q;
    assign cnt_flat[g*RW +: RW]  = cnt_q;
  end
endmodule

// File: rtl/dmac_cfg_ctl.sv
module dmac_cfg_ctl
  import dmac_cfg_pkg::*;
#(
  parameter int N_CH = NCH,
  parameter int MW   = MODE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dec_t                    dec,
  input  logic [7:0]              wdata,
  input  logic [N_CH-1:0]         tc_set,
  input  logic                    tmp_load,
  input  logic [7:0]              tmp_data,
  output logic [7:0]              cmd_q,
  output logic [N_CH-1:0]         mask_q,
  output logic [N_CH-1:0]         req_q,
  output logic [N_CH-1:0]         tc_q,
  output logic [N_CH*MW-1:0]      mode_flat,
  output logic [7:0]              tmp_q,
  output logic                    byte_hi,
  output logic [$clog2(N_CH)-1:0] mode_ptr
);
  localparam int SW = $clog2(N_CH);

  logic          clr_all;
  logic [SW-1:0] sel;
  assign clr_all = rst || dec.mclr_wr;
  assign sel     = wdata[SW-1:0];

  always_ff @(posedge clk) begin
    if (clr_all) begin
      cmd_q    <= '0;
      tmp_q    <= '0;
      byte_hi  <= 1'b0;
      mode_ptr <= '0;
    end else begin
      if (dec.cmd_wr) cmd_q <= wdata;
      if (tmp_load)   tmp_q <= tmp_data;
      if (dec.ptrclr_wr)               byte_hi <= 1'b0;
      else if (dec.ptrset_rd)          byte_hi <= 1'b1;
      else if (dec.ch_wr || dec.ch_rd) byte_hi <= !byte_hi;
      if (dec.mctrclr_rd)   mode_ptr <= '0;
      else if (dec.mode_rd) mode_ptr <= mode_ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_bit
    logic          msk_b, req_b, tc_b;
    logic [MW-1:0] mode_b;
    logic          mine;
    assign mine = (sel == SW'(g));

    always_ff @(posedge clk) begin
      if (clr_all) begin
        msk_b <= 1'b1;
        req_b <= 1'b0;
        tc_b  <= 1'b0;
      end else begin
        if (dec.unmask_wr)             msk_b <= 1'b0;
        else if (dec.amask_wr)         msk_b <= wdata[g];
        else if (dec.smask_wr && mine) msk_b <= wdata[2];
        if (dec.req_wr && mine) req_b <= wdata[2];
        tc_b <= (tc_b && !dec.stat_rd) || tc_set[g];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                        mode_b <= '0;
      else if (dec.mode_wr && mine)   mode_b <= wdata[7 -: MW];
    end

    assign mask_q[g]              = msk_b;
    assign req_q[g]               = req_b;
    assign tc_q[g]                = tc_b;
    assign mode_flat[g*MW +: MW]  = mode_b;
  end
endmodule

// File: rtl/dmac_cfg_port.sv
module dmac_cfg_port
  import dmac_cfg_pkg::*;
#(
  parameter int N_CH = NCH,
  parameter int RW   = REG_W,
  parameter int MW   = MODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 hold_ack,
  input  logic                 rd_stb,
  input  logic                 wr_stb,
  input  logic [3:0]           addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 rvalid,
  input  logic [N_CH-1:0]      req_lines,
  input  logic [N_CH-1:0]      tc_set,
  input  logic                 tmp_load,
  input  logic [7:0]           tmp_data,
  output logic [7:0]           cmd_o,
  output logic [N_CH*MW-1:0]   mode_o,
  output logic [N_CH-1:0]      mask_o,
  output logic [N_CH-1:0]      swreq_o,
  output logic [N_CH*RW-1:0]   chaddr_o,
  output logic [N_CH*RW-1:0]   chcnt_o
);
  localparam int SW = $clog2(N_CH);

  dec_t             dec;
  logic             acc_rd;
  logic             byte_hi;
  logic [SW-1:0]    mode_ptr;
  logic [N_CH-1:0]  tc_q;
  logic [7:0]       tmp_q;
  logic [7:0]       rd_mux;
  logic [SW-1:0]    ch_idx;
  logic [RW-1:0]    adr_a  [N_CH];
  logic [RW-1:0]    cnt_a  [N_CH];
  logic [MW-1:0]    mode_a [N_CH];
  logic [RW-1:0]    sel16;

  assign ch_idx = addr[SW:1];

  dmac_cfg_decode u_dec (
    .cs_n(cs_n), .hold_ack(hold_ack), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr(addr), .dec(dec), .acc_rd(acc_rd)
  );

  dmac_cfg_chregs #(.N_CH(N_CH), .RW(RW)) u_ch (
    .clk(clk), .rst(rst), .wr_en(dec.ch_wr), .ch_sel(ch_idx),
    .is_cnt(addr[0]), .byte_hi(byte_hi), .wdata(wdata),
    .addr_flat(chaddr_o), .cnt_flat(chcnt_o)
  );

  dmac_cfg_ctl #(.N_CH(N_CH), .MW(MW)) u_ctl (
    .clk(clk), .rst(rst), .dec(dec), .wdata(wdata), .tc_set(tc_set),
    .tmp_load(tmp_load), .tmp_data(tmp_data), .cmd_q(cmd_o),
    .mask_q(mask_o), .req_q(swreq_o), .tc_q(tc_q), .mode_flat(mode_o),
    .tmp_q(tmp_q), .byte_hi(byte_hi), .mode_ptr(mode_ptr)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_view
    assign adr_a[g]  = chaddr_o[g*RW +: RW];
    assign cnt_a[g]  = chcnt_o[g*RW +: RW];
    assign mode_a[g] = mode_o[g*MW +: MW];
  end

  always_comb begin
    rd_mux = '0;
    sel16  = addr[0] ? cnt_a[ch_idx] : adr_a[ch_idx];
    if (!addr[3]) begin
      rd_mux = byte_hi ? sel16[RW-1 -: 8] : sel16[7:0];
    end else begin
      case (addr)
        OFS_CMD:              rd_mux = 8'({req_lines, tc_q});
        OFS_REQ:              rd_mux = 8'(swreq_o);
        OFS_SMASK, OFS_AMASK: rd_mux = 8'(mask_o);
        OFS_MODE:             rd_mux = 8'({mode_a[mode_ptr], mode_ptr});
        OFS_MCLR:             rd_mux = tmp_q;
        default:              rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= acc_rd;
      if (acc_rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dmac_cfg_port_chk.sv
module dmac_cfg_port_chk #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cs_n,
  input logic            hold_ack,
  input logic            rd_stb,
  input logic            wr_stb,
  input logic [3:0]      addr,
  input logic [7:0]      cmd_o,
  input logic [N_CH-1:0] mask_o,
  input logic            rvalid,
  input logic            byte_hi
);
  logic ok_wr, ok_rd;
  assign ok_wr = !cs_n && !hold_ack && wr_stb && !rd_stb;
  assign ok_rd = !cs_n && !hold_ack && rd_stb && !wr_stb;

  AST_GATED_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (cs_n || hold_ack) |=> ($stable(cmd_o) && $stable(mask_o))); // R1
  AST_PTR_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    ((ok_wr || ok_rd) && !addr[3]) |=> (byte_hi != $past(byte_hi))); // R2
  AST_SMASK_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (ok_wr && addr == 4'd10) |=> ($countones(mask_o ^ $past(mask_o)) <= 1)); // R6
  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (ok_wr && addr == 4'd12) |=> !byte_hi); // R8
  AST_PTR_SET: assert property (@(posedge clk) disable iff (rst)
    (ok_rd && addr == 4'd12) |=> byte_hi); // R8
  AST_MCLR_STATE: assert property (@(posedge clk) disable iff (rst)
    (ok_wr && addr == 4'd13) |=> (mask_o == '1 && cmd_o == '0 && !byte_hi)); // R9
  AST_UNMASK_ALL: assert property (@(posedge clk) disable iff (rst)
    (ok_wr && addr == 4'd14) |=> (mask_o == '0)); // R10
  AST_RESET_MASKED: assert property (@(posedge clk)
    rst |=> (mask_o == '1 && !rvalid && cmd_o == '0)); // R11
  AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(ok_rd)); // R12
endmodule

bind dmac_cfg_port dmac_cfg_port_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .hold_ack(hold_ack), .rd_stb(rd_stb),
  .wr_stb(wr_stb), .addr(addr), .cmd_o(cmd_o), .mask_o(mask_o),
  .rvalid(rvalid), .byte_hi(byte_hi)
);

// File: tb/dmac_cfg_port_bench.sv
module dmac_cfg_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, hold_ack = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  req_lines = 4'b1010;
  logic [3:0]  tc_set = '0;
  logic        tmp_load = 1'b0;
  logic [7:0]  tmp_data = '0;
  logic [7:0]  rdata, cmd_o;
  logic        rvalid;
  logic [23:0] mode_o;
  logic [3:0]  mask_o, swreq_o;
  logic [63:0] chaddr_o, chcnt_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit chk_on = 1'b0;

  always #10 clk = !clk;

  dmac_cfg_port u_dmac_cfg_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .hold_ack(hold_ack), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .req_lines(req_lines), .tc_set(tc_set), .tmp_load(tmp_load), .tmp_data(tmp_data),
    .cmd_o(cmd_o), .mode_o(mode_o), .mask_o(mask_o), .swreq_o(swreq_o),
    .chaddr_o(chaddr_o), .chcnt_o(chcnt_o)
  );

  // reference model
  int m_adr[4], m_cnt[4], m_mode[4];
  int m_cmd, m_mask, m_req, m_tc, m_tmp, m_hi, m_ptr, m_rdata, m_rvalid;
  string m_tag = "R12";

  task automatic soft_clear();
    m_cmd = 0; m_mask = 15; m_req = 0; m_tc = 0; m_tmp = 0; m_hi = 0; m_ptr = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      soft_clear();
      for (int i = 0; i < 4; i++) begin m_adr[i] = 0; m_cnt[i] = 0; m_mode[i] = 0; end
      m_rvalid = 0; m_rdata = 0;
    end else begin
      automatic bit ok = !cs_n && !hold_ack && (rd_stb != wr_stb);
      automatic bit rd = ok && rd_stb;
      automatic bit wr = ok && wr_stb;
      automatic int a = int'(addr);
      automatic int d = int'(wdata);
      automatic int ch = d % 4;
      automatic int tc_next;
      m_rvalid = rd;
      tc_next = m_tc;
      if (rd) begin
        if (a < 8) begin
          automatic int v = (a % 2) ? m_cnt[a/2] : m_adr[a/2];
          m_rdata = m_hi ? (v >> 8) & 255 : v & 255;
          m_hi = 1 - m_hi; m_tag = "R2";
        end else case (a)
          8:  begin m_rdata = int'(req_lines) * 16 + m_tc; tc_next = 0; m_tag = "R4"; end
          9:  begin m_rdata = m_req; m_tag = "R5"; end
          10, 15: begin m_rdata = m_mask; m_tag = "R6"; end
          11: begin m_rdata = m_mode[m_ptr] * 4 + m_ptr; m_ptr = (m_ptr + 1) % 4; m_tag = "R7"; end
          12: begin m_rdata = 0; m_hi = 1; m_tag = "R8"; end
          13: begin m_rdata = m_tmp; m_tag = "R9"; end
          default: begin m_rdata = 0; m_ptr = 0; m_tag = "R7"; end
        endcase
      end
      tc_next = tc_next | int'(tc_set);
      m_tc = tc_next;
      if (tmp_load) m_tmp = int'(tmp_data);
      if (wr) begin
        if (a < 8) begin
          if (a % 2) m_cnt[a/2] = m_hi ? (m_cnt[a/2] & 255) | (d << 8) : (m_cnt[a/2] & 65280) | d;
          else       m_adr[a/2] = m_hi ? (m_adr[a/2] & 255) | (d << 8) : (m_adr[a/2] & 65280) | d;
          m_hi = 1 - m_hi;
        end else case (a)
          8:  m_cmd = d;
          9:  m_req = ((d >> 2) & 1) ? (m_req | (1 << ch)) : (m_req & ~(1 << ch));
          10: m_mask = ((d >> 2) & 1) ? (m_mask | (1 << ch)) : (m_mask & ~(1 << ch));
          11: m_mode[ch] = d >> 2;
          12: m_hi = 0;
          13: soft_clear();
          14: m_mask = 0;
          default: m_mask = d & 15;
        endcase
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      for (int i = 0; i < 4; i++) begin
        check("R3 address", int'(chaddr_o[i*16 +: 16]), m_adr[i]);
        check("R3 count", int'(chcnt_o[i*16 +: 16]), m_cnt[i]);
        check("R7 mode", int'(mode_o[i*6 +: 6]), m_mode[i]);
      end
      check("R4 command", int'(cmd_o), m_cmd);
      check("R6 mask", int'(mask_o), m_mask);
      check("R5 request", int'(swreq_o), m_req);
      check("R12 rvalid", int'(rvalid), m_rvalid);
      if (m_rvalid) check({m_tag, " rdata"}, int'(rdata), m_rdata);
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog: actual %0d expected %0d", cyc, 50000);
      summary();
    end
  end

  task automatic drive(bit c, bit h, bit r, bit w, int a, int d, int tcs, bit tl, int td);
    @(negedge clk);
    cs_n = c; hold_ack = h; rd_stb = r; wr_stb = w;
    addr = 4'(a); wdata = 8'(d); tc_set = 4'(tcs); tmp_load = tl; tmp_data = 8'(td);
  endtask
  task automatic wr(int a, int d); drive(0, 0, 0, 1, a, d, 0, 0, 0); endtask
  task automatic rd(int a);        drive(0, 0, 1, 0, a, 0, 0, 0, 0); endtask
  task automatic idle();           drive(1, 0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_on = 1'b1;
    // R11: reset state
    check("R11 mask", int'(mask_o), 15);
    check("R11 cmd", int'(cmd_o), 0);
    check("R11 rvalid", int'(rvalid), 0);
    @(negedge clk); rst = 1'b0;
    // R3 R2: program all channel registers low byte then high
    for (int c = 0; c < 4; c++) begin
      wr(c*2, 16 + c);   wr(c*2, 160 + c);
      wr(c*2+1, 48 + c); wr(c*2+1, 224 + c);
    end
    rd(4); rd(4); rd(7); rd(7);
    // R2 R8: read between halves, pointer clear and set
    rd(0); wr(12, 0); rd(0); rd(12); rd(2); wr(1, 85); wr(12, 0); wr(1, 119); wr(1, 136);
    idle();
    check("R2 count0", int'(chcnt_o[15:0]), 16'h8877);
    // R1: gated and double-strobe accesses
    drive(1, 0, 0, 1, 8, 165, 0, 0, 0);
    drive(0, 1, 0, 1, 8, 90, 0, 0, 0);
    drive(0, 0, 1, 1, 15, 0, 0, 0, 0);
    drive(0, 1, 1, 0, 13, 0, 0, 0, 0);
    idle();
    check("R1 cmd", int'(cmd_o), 0);
    check("R1 rvalid", int'(rvalid), 0);
    check("R1 mask", int'(mask_o), 15);
    // R4 R12: command, status with terminal counts
    wr(8, 60);
    drive(1, 0, 0, 0, 0, 0, 5, 0, 0);
    rd(8); rd(8);
    drive(0, 0, 1, 0, 8, 0, 2, 0, 0);
    rd(8);
    // R5: software requests
    wr(9, 5); wr(9, 7); wr(9, 1); rd(9);
    // R10 R6: masks
    wr(14, 0); idle();
    check("R10 mask", int'(mask_o), 0);
    wr(10, 6); wr(15, 9); rd(10); rd(15); wr(10, 0); rd(15);
    // R7: modes and readback counter
    wr(11, 164); wr(11, 93); wr(11, 242); wr(11, 15);
    for (int i = 0; i < 5; i++) rd(11);
    rd(14); rd(11);
    // R12 R9: temporary byte, master clear
    drive(1, 0, 0, 0, 0, 0, 0, 1, 110);
    rd(13);
    rd(0);
    drive(0, 0, 0, 1, 13, 0, 8, 1, 33);
    idle();
    check("R9 mask", int'(mask_o), 15);
    check("R9 cmd", int'(cmd_o), 0);
    check("R9 request", int'(swreq_o), 0);
    rd(13); rd(8); rd(0); rd(11);
    idle(); idle();
    summary();
  end
endmodule